// File: doc/BRIEF.md
# MDIO Command Register Master

This block is a Clause 22 management master for one MDIO bus. Software controls it through one 32-bit command word. A write to that word supplies the operation, the PHY address, the register address and the write data. If the start bit is set in the same write, the block sends the management frame on MDC and MDIO.

While the frame runs, the start bit reads back as a busy flag. When the frame ends, busy clears and a one-cycle done pulse is raised. After a read, the same word returns the 16 captured data bits and a fail flag. The fail flag is set when no PHY answered during turnaround, and that case also raises a one-cycle error pulse. Both pulses are meant to feed an interrupt controller.

MDC is derived from the system clock by a parameter. It toggles only while a frame is in flight. MDIO is driven through a separate data output and output enable, and the bus level comes back on its own input.

Top module: `mdio_cmd_master`

## Requirements
- R1: While reset is held and right after it, the command word reads all zeros, MDC is low, the MDIO output enable is low and neither pulse is raised.
- R2: The command word reads busy at bit 29, fail at bit 28, opcode at bits 27:26 (1 = write, 2 = read), PHY address at bits 25:21, register address at bits 20:16 and data at bits 15:0. Bits 31:30 read zero. Any accepted write clears fail. A write with bit 29 clear loads the fields and sends no frame.
- R3: A write with bit 29 set and opcode 1 or 2 starts a frame, and bit 29 reads one from the next cycle until the frame completes.
- R4: A frame is 64 MDC periods, sent most significant bit first in this order: 32 ones, start bits 01, the two opcode bits, the 5-bit PHY address, the 5-bit register address, two turnaround bits (10 on a write), then 16 data bits. MDIO output and output enable change only while MDC is low and stay stable while MDC is high.
- R5: MDC stays low while idle. During a frame its period is 2*CLK_HALF system clock cycles.
- R6: On a read, the output enable is low for the last 18 bits (turnaround and data). MDIO is sampled on each MDC rising edge, and the 16 data bits appear in bits 15:0 when the read completes.
- R7: On a read, if MDIO is high when sampled in the second turnaround bit, fail reads one after completion and the error pulse is raised in the completion cycle.
- R8: The done pulse lasts one cycle after every frame, in the same cycle that busy first reads zero.
- R9: Writes to the command word while busy reads one have no effect on any field or on the frame being sent.
- R10: A write with bit 29 set and opcode 0 or 3 sends no frame and leaves busy at zero. In the next cycle it sets fail and raises the error pulse without the done pulse.
- R11: The MDIO output enable is low whenever busy reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Value written to the command word |
| reg_rdata | output | 32 | Current command word contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO bus level |
| done_pulse | output | 1 | One-cycle pulse when a frame completes |
| err_pulse | output | 1 | One-cycle pulse on a failed read or a bad opcode |

## Verification
The hardest case to reach from the ports is a command write that lands while a frame is running, because it has to arrive inside the frame's window. The driver starts a write frame, waits a fixed number of clocks so that it is well inside the preamble, and then writes an inverted command with start set. The scoreboard then requires the serialized frame and the final word to match the first command exactly. The read-fail path needs a PHY model that can stay silent. The bench model ties its answer to a per-transaction response flag, so the same read is run once with an answering PHY and once with a silent one.

// File: rtl/mdio_cmd_pkg.sv
`timescale 1ns/1ps
package mdio_cmd_pkg;

    localparam int OP_W     = 2;
    localparam int PHY_W    = 5;
    localparam int REG_W    = 5;
    localparam int DATA_W   = 16;

    // command word bit positions (software decodes these)
    localparam int BUSY_BIT = 29;
    localparam int FAIL_BIT = 28;
    localparam int OP_LSB   = 26;
    localparam int PHY_LSB  = 21;
    localparam int REG_LSB  = 16;

    typedef enum logic [OP_W-1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_RSVD  = 2'd3
    } mdio_op_e;

    typedef struct packed {
        mdio_op_e            op;
        logic [PHY_W-1:0]    phy;
        logic [REG_W-1:0]    regad;
        logic [DATA_W-1:0]   data;
    } mdio_cmd_t;

endpackage

// File: rtl/mdio_mdc_div.sv
`timescale 1ns/1ps
module mdio_mdc_div #(
    parameter int CLK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic mdc_rise,
    output logic mdc_fall
);
    localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    wrap;

    assign wrap = (st_q.cnt == CW'(CLK_HALF - 1));

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc      = st_q.mdc;
    assign mdc_rise = run && wrap && !st_q.mdc;
    assign mdc_fall = run && wrap &&  st_q.mdc;

endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq
    import mdio_cmd_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  mdio_cmd_t         cmd,
    input  logic              mdc_rise,
    input  logic              mdc_fall,
    input  logic              mdio_i,
    output logic              active,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              finish,
    output logic [DATA_W-1:0] rd_data,
    output logic              ta_fail
);
    localparam int TA_IDX = PRE_LEN + 2 + OP_W + PHY_W + REG_W;
    localparam int FLEN   = TA_IDX + 2 + DATA_W;
    localparam int IW     = $clog2(FLEN);

    typedef struct packed {
        logic              active;
        logic              rd;
        logic [IW-1:0]     idx;
        logic [FLEN-1:0]   shreg;
        logic [DATA_W-1:0] rdsh;
        logic              fail;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    last;

    assign last = (st_q.idx == IW'(FLEN - 1));

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.rd     = (cmd.op == OP_READ);
            st_d.idx    = '0;
            st_d.fail   = 1'b0;
            st_d.shreg  = {{PRE_LEN{1'b1}}, 2'b01, cmd.op, cmd.phy, cmd.regad,
                           (st_d.rd ? 2'b11 : 2'b10),
                           (st_d.rd ? {DATA_W{1'b1}} : cmd.data)};
        end else if (st_q.active) begin
            if (mdc_rise && st_q.rd) begin
                if (st_q.idx == IW'(TA_IDX + 1))
                    st_d.fail = mdio_i;
                if (st_q.idx >= IW'(TA_IDX + 2))
                    st_d.rdsh = {st_q.rdsh[DATA_W-2:0], mdio_i};
            end
            if (mdc_fall) begin
                if (last) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.idx   = st_q.idx + 1'b1;
                    st_d.shreg = {st_q.shreg[FLEN-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active  = st_q.active;
    assign mdio_o  = st_q.shreg[FLEN-1];
    assign mdio_oe = st_q.active && !(st_q.rd && (st_q.idx >= IW'(TA_IDX)));
    assign finish  = st_q.active && mdc_fall && last;
    assign rd_data = st_q.rdsh;
    assign ta_fail = st_q.fail;

endmodule

// File: rtl/mdio_cmd_master.sv
`timescale 1ns/1ps
module mdio_cmd_master
    import mdio_cmd_pkg::*;
#(
    parameter int CLK_HALF = 2,
    parameter int PRE_LEN  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i,
    output logic        done_pulse,
    output logic        err_pulse
);
    typedef struct packed {
        logic      busy;
        logic      fail;
        mdio_cmd_t cmd;
        logic      done;
        logic      err;
    } top_st_t;

    top_st_t           st_d, st_q;
    mdio_cmd_t         wr_cmd;
    logic              start;
    logic              run;
    logic              mdc_rise, mdc_fall;
    logic              finish;
    logic [DATA_W-1:0] rd_data;
    logic              ta_fail;
    logic              unused_wbits;

    assign wr_cmd.op    = mdio_op_e'(reg_wdata[OP_LSB +: OP_W]);
    assign wr_cmd.phy   = reg_wdata[PHY_LSB +: PHY_W];
    assign wr_cmd.regad = reg_wdata[REG_LSB +: REG_W];
    assign wr_cmd.data  = reg_wdata[DATA_W-1:0];
    assign unused_wbits = ^{reg_wdata[31:30], reg_wdata[FAIL_BIT]};

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        start     = 1'b0;
        if (reg_wr && !st_q.busy) begin
            st_d.cmd  = wr_cmd;
            st_d.fail = 1'b0;
            if (reg_wdata[BUSY_BIT]) begin
                if (wr_cmd.op == OP_WRITE || wr_cmd.op == OP_READ) begin
                    st_d.busy = 1'b1;
                    start     = 1'b1;
                end else begin
                    st_d.fail = 1'b1;
                    st_d.err  = 1'b1;
                end
            end
        end
        if (finish) begin
            st_d.busy = 1'b0;
            st_d.done = 1'b1;
            if (st_q.cmd.op == OP_READ) begin
                st_d.cmd.data = rd_data;
                st_d.fail     = ta_fail;
                st_d.err      = ta_fail;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mdio_mdc_div #(.CLK_HALF(CLK_HALF)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .mdc      (mdc),
        .mdc_rise (mdc_rise),
        .mdc_fall (mdc_fall)
    );

    mdio_frame_seq #(.PRE_LEN(PRE_LEN)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (wr_cmd),
        .mdc_rise (mdc_rise),
        .mdc_fall (mdc_fall),
        .mdio_i   (mdio_i),
        .active   (run),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .finish   (finish),
        .rd_data  (rd_data),
        .ta_fail  (ta_fail)
    );

    assign reg_rdata  = {2'b00, st_q.busy, st_q.fail, st_q.cmd.op, st_q.cmd.phy,
                         st_q.cmd.regad, st_q.cmd.data};
    assign done_pulse = st_q.done;
    assign err_pulse  = st_q.err;

endmodule

// File: rtl/mdio_cmd_master_chk.sv
`timescale 1ns/1ps
module mdio_cmd_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        done_pulse,
    input logic        err_pulse
);
    // R5
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[29] |-> !mdc);

    // R11
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[29] |-> !mdio_oe);

    // R4
    mdio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !reg_rdata[29]);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    // R9
    busy_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[29] && $past(reg_rdata[29])) |-> $stable(reg_rdata[27:0]));

    // R7
    err_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (!reg_rdata[29] && reg_rdata[28]));

endmodule

bind mdio_cmd_master mdio_cmd_master_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_rdata  (reg_rdata),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .done_pulse (done_pulse),
    .err_pulse  (err_pulse)
);

// File: tb/test_mdio_cmd_master.sv
`timescale 1ns/1ps
module test_mdio_cmd_master;
    localparam int CLK_HALF = 2;
    localparam int PRE_LEN  = 32;

    typedef struct {
        logic [63:0] frame;
        logic [63:0] oe;
        logic [31:0] reg_exp;
        bit          done_exp;
        bit          err_exp;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;
    logic        done_pulse, err_pulse;

    int          vectors = 0;
    int          miscompares = 0;
    int          rises = 0;
    logic [63:0] cap_o = '0;
    logic [63:0] cap_oe = '0;
    bit          resp_en = 1'b0;
    logic [15:0] resp_data = '0;
    time         t_prev = 0;
    time         t_last = 0;
    exp_t        q[$];
    exp_t        mon_e;

    always #2.5 clk = ~clk;

    mdio_cmd_master #(.CLK_HALF(CLK_HALF), .PRE_LEN(PRE_LEN)) i_mdio_cmd_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .mdc        (mdc),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .mdio_i     (mdio_i),
        .done_pulse (done_pulse),
        .err_pulse  (err_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic resp_bit(input int k);
        if (!resp_en) return 1'b1;
        if (k == 47) return 1'b0;
        if (k >= 48 && k <= 63) return resp_data[63-k];
        return 1'b1;
    endfunction

    // PHY model: capture on MDC rise, answer after MDC fall
    always @(posedge mdc) begin
        cap_o  = {cap_o[62:0], mdio_o};
        cap_oe = {cap_oe[62:0], mdio_oe};
        rises++;
        t_prev = t_last;
        t_last = $time;
    end

    always @(negedge mdc) mdio_i = resp_bit(rises);

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (done_pulse || err_pulse)) begin
            if (q.size() == 0) begin
                chk(1'b0, "R8 completion with nothing pending", 64'(done_pulse), 64'd0);
            end else begin
                mon_e = q.pop_front();
                chk(done_pulse == mon_e.done_exp, "R8 done pulse", 64'(done_pulse), 64'(mon_e.done_exp));
                chk(err_pulse == mon_e.err_exp, "R7 R10 error pulse", 64'(err_pulse), 64'(mon_e.err_exp));
                chk(reg_rdata == mon_e.reg_exp, "R2 R6 command word after completion",
                    64'(reg_rdata), 64'(mon_e.reg_exp));
                if (mon_e.done_exp) begin
                    chk(rises == 64, "R4 bit count", 64'(rises), 64'd64);
                    chk(cap_oe == mon_e.oe, "R6 drive and release pattern", cap_oe, mon_e.oe);
                    chk((cap_o & mon_e.oe) == (mon_e.frame & mon_e.oe), "R4 frame bits",
                        cap_o & mon_e.oe, mon_e.frame & mon_e.oe);
                end else begin
                    chk(rises == 0, "R10 no MDC activity", 64'(rises), 64'd0);
                end
            end
        end
    end

    task automatic run_cmd(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] data, input bit respond, input logic [15:0] rdat,
                           input bit poke);
        exp_t e;
        bit   rd    = (op == 2'd2);
        bit   valid = (op == 2'd1) || (op == 2'd2);
        bit   fail  = !valid || (rd && !respond);
        logic [31:0] launched = {2'b00, 1'b1, 1'b0, op, phy, rg, data};
        e.frame    = {32'hFFFF_FFFF, 2'b01, op, phy, rg, (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : data)};
        e.oe       = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
        e.done_exp = valid;
        e.err_exp  = fail;
        e.reg_exp  = {2'b00, 1'b0, fail, op, phy, rg,
                      (valid && rd) ? (respond ? rdat : 16'hFFFF) : data};
        q.push_back(e);
        resp_en   = respond;
        resp_data = rdat;
        rises     = 0;
        cap_o     = '0;
        cap_oe    = '0;
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = launched;
        @(negedge clk);
        reg_wr    = 1'b0;
        if (valid)
            chk(reg_rdata == launched, "R3 busy and fields after launch", 64'(reg_rdata), 64'(launched));
        if (poke) begin
            repeat (60) @(negedge clk);
            reg_wr    = 1'b1;
            reg_wdata = ~launched | 32'h2000_0000;
            @(negedge clk);
            reg_wr    = 1'b0;
            @(negedge clk);
            chk(reg_rdata == launched, "R9 write while busy ignored", 64'(reg_rdata), 64'(launched));
        end
        while (reg_rdata[29]) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R5 R11 idle MDC and enable",
            64'({mdc, mdio_oe}), 64'd0);
    endtask

    initial begin
        #1_000_000;
        chk(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(reg_rdata == 32'd0 && !mdc && !mdio_oe && !done_pulse && !err_pulse,
            "R1 reset state", 64'(reg_rdata), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(reg_rdata == 32'd0 && !mdc && !mdio_oe, "R1 state after reset", 64'(reg_rdata), 64'd0);

        // R4 R5 plain write frame
        run_cmd(2'd1, 5'h05, 5'h1A, 16'hBEEF, 1'b0, 16'h0, 1'b0);
        chk((t_last - t_prev) == time'(2 * CLK_HALF * 5), "R5 MDC period",
            64'(t_last - t_prev), 64'(2 * CLK_HALF * 5));

        // R6 reads with an answering PHY
        run_cmd(2'd2, 5'h1F, 5'h00, 16'h0000, 1'b1, 16'h1234, 1'b0);
        run_cmd(2'd2, 5'h00, 5'h1F, 16'h5555, 1'b1, 16'hA5C3, 1'b0);

        // R7 read with a silent PHY
        run_cmd(2'd2, 5'h11, 5'h02, 16'h0000, 1'b0, 16'h0, 1'b0);

        // R9 write during busy, and fail cleared by the next launch
        run_cmd(2'd1, 5'h1E, 5'h15, 16'h8001, 1'b0, 16'h0, 1'b1);

        // R10 bad opcodes
        run_cmd(2'd0, 5'h03, 5'h04, 16'h1111, 1'b0, 16'h0, 1'b0);
        run_cmd(2'd3, 5'h0A, 5'h0B, 16'h2222, 1'b0, 16'h0, 1'b0);

        // R2 load without start: reserved and fail bits written high are not kept
        rises = 0;
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wdata = {2'b11, 1'b0, 1'b1, 2'd1, 5'h07, 5'h09, 16'hCAFE};
        @(negedge clk);
        reg_wr    = 1'b0;
        chk(reg_rdata == {2'b00, 1'b0, 1'b0, 2'd1, 5'h07, 5'h09, 16'hCAFE}, "R2 field load without start",
            64'(reg_rdata), 64'({2'b00, 1'b0, 1'b0, 2'd1, 5'h07, 5'h09, 16'hCAFE}));
        repeat (20) @(negedge clk);
        chk(rises == 0 && !mdio_oe, "R2 no frame without start", 64'(rises), 64'd0);

        chk(q.size() == 0, "R8 every launch completed", 64'(q.size()), 64'd0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule